// File: doc/BRIEF.md
# Reset Pad Controller with Cause Capture

This block governs a single bidirectional chip pad that does double duty. By default the pad is the external reset input. Software may instead turn it into an open-drain general-purpose output. The pad never has a general-purpose input mode. A low level held on the pad at power-up would otherwise keep the chip in reset.

The block merges four reset sources into one internal reset:

- power-on, which is asynchronous;
- low-voltage;
- a low level on the pad;
- an internal request.

Whatever the source, the block pulls the pad low for a fixed stretch of 66 clock cycles and keeps the internal reset asserted for the same cycles. It also records the cause in a one-hot status register. That register stays readable until the next reset replaces it. A stop-mode entry request is granted only while the pad is in its reset role and no reset is in progress.

Top module: `rstpad_ctrl`

## Requirements
- R1: While `por_n` is low, `pad_oe` is 1, `sys_rst_n` is 0, `pad_pu_en` is 1, status reads 4'b0001 and config reads 3'b110. After `por_n` rises, `pad_oe` stays 1 for 68 samples: 2 reset-synchronizer cycles plus the stretch.
- R2: A runtime reset (low-voltage, pad or internal) drives `pad_oe` high and `sys_rst_n` low for exactly 66 consecutive cycles, starting on the clock edge at which the request is accepted.
- R3: Status bits in `rd_data[3:0]` with `rd_sel`=0 are: bit0 power-on, bit1 low-voltage, bit2 pad, bit3 internal. Exactly one bit is set. Requests accepted on the same edge resolve as low-voltage over pad over internal.
- R4: The status value does not change between resets.
- R5: A pad low level, seen through a 2-stage synchronizer, must be held for 2 consecutive synchronized samples to be accepted. A low applied just after edge 0 starts the stretch at edge 4 and not earlier.
- R6: A pad low lasting one clock period causes no reset.
- R7: The pad's own low drive during a stretch is not taken as an external request. No reset follows when the stretch ends.
- R8: Low-voltage, pad and internal requests arriving during a stretch neither extend it nor change the status.
- R9: The config register, read with `rd_sel`=1, has bit0 = GPIO mode, bit1 = output level and bit2 = pull-up. In GPIO mode `pad_oe` equals the inverse of the level bit, `pad_pu_en` equals the pull-up bit, and a pad low starts no reset.
- R10: Every reset returns the config to 3'b110, the reset role, and `pad_pu_en` is 1 throughout the stretch.
- R11: `stop_grant` is 1 one cycle after `stop_req` only when the pad is in its reset role and no stretch is running. Otherwise it is 0.
- R12: Config writes during a stretch are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| lvd_req | input | 1 | Low-voltage reset request |
| int_req | input | 1 | Internal reset request |
| pad_in | input | 1 | Level seen on the pad |
| pad_oe | output | 1 | Pad pull-low enable (open drain) |
| pad_pu_en | output | 1 | Pad pull-up enable |
| cfg_we | input | 1 | Config write strobe |
| cfg_wdata | input | 3 | Config write data |
| stop_req | input | 1 | Stop-mode entry request |
| stop_grant | output | 1 | Stop-mode entry granted |
| rd_sel | input | 1 | Read select: 0 status, 1 config |
| rd_data | output | 8 | Read data |
| sys_rst_n | output | 1 | Internal chip reset, active low |

## Verification
The bench hunts for an off-by-one stretch length. A counter loaded or compared one value off would give 65 or 67 low cycles instead of 66. It aims at the pad's own low drive leaking into the synchronizer. A design that let it leak would fire a second reset just after each stretch. It also checks single-period glitches, requests landing in the middle of a stretch, and simultaneous sources. A weak filter would reset on a glitch. Broken blocking would lengthen the stretch or overwrite the recorded cause. A wrong priority would record a pad or internal cause where a low-voltage one won. Finally it checks that GPIO mode both ignores the pad and refuses stop entry, and that every reset restores the reset role.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int CAUSE_W = 4;
  localparam int C_POR   = 0;
  localparam int C_LVD   = 1;
  localparam int C_PIN   = 2;
  localparam int C_INT   = 3;
  localparam int CFG_W   = 3;

  typedef struct packed {
    logic pu;     // bit2: pull-up in GPIO mode
    logic level;  // bit1: GPIO output level (0 pulls low)
    logic gpio;   // bit0: 1 = open-drain output role
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{pu: 1'b1, level: 1'b1, gpio: 1'b0};
endpackage

// File: rtl/rp_rst_sync.sv
module rp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/rp_pin_filter.sv
module rp_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_in,
  input  logic blank,
  output logic pin_req
);
  localparam int HIST_W = FILT_LEN - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [HIST_W-1:0]      hist_q, hist_d;
  logic                   sync_lo;

  assign sync_lo = ~sync_q[SYNC_STAGES-1];

  // Synchronizer forced high while blanked so self-drive never lingers.
  always_comb begin
    if (blank) sync_d = '1;
    else       sync_d = {sync_q[SYNC_STAGES-2:0], pad_in};
  end

  generate
    if (HIST_W == 1) begin : g_hist1
      always_comb hist_d = blank ? 1'b0 : sync_lo;
    end else begin : g_histn
      always_comb hist_d = blank ? '0 : {hist_q[HIST_W-2:0], sync_lo};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  assign pin_req = ~blank & sync_lo & (&hist_q);
endmodule

// File: rtl/rp_stretch.sv
module rp_stretch #(
  parameter int STRETCH_CYC = 66
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active
);
  localparam int CW = $clog2(STRETCH_CYC + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(STRETCH_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign active = (cnt_q != '0);
  assign cnt_en = load | active;

  always_comb begin
    if (load) cnt_d = CNT_INIT;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_INIT;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rp_cause.sv
module rp_cause
  import rp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               lvd_req,
  input  logic               pin_req,
  input  logic               int_req,
  output logic               fire,
  output logic [CAUSE_W-1:0] status
);
  logic [CAUSE_W-1:0] stat_q, stat_d;

  assign fire = ~busy & (lvd_req | pin_req | int_req);

  always_comb begin
    stat_d = '0;
    if (lvd_req)      stat_d[C_LVD] = 1'b1;
    else if (pin_req) stat_d[C_PIN] = 1'b1;
    else              stat_d[C_INT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stat_q <= CAUSE_W'(1) << C_POR;
    else if (fire) stat_q <= stat_d;
  end

  assign status = stat_q;
endmodule

// File: rtl/rstpad_ctrl.sv
module rstpad_ctrl
  import rp_pkg::*;
#(
  parameter int STRETCH_CYC     = 66,
  parameter int SYNC_STAGES     = 2,
  parameter int FILT_LEN        = 2,
  parameter int RST_SYNC_STAGES = 2,
  parameter int DW              = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          lvd_req,
  input  logic          int_req,
  input  logic          pad_in,
  output logic          pad_oe,
  output logic          pad_pu_en,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_wdata,
  input  logic          stop_req,
  output logic          stop_grant,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          sys_rst_n
);
  logic               rst_sync_n;
  logic               active;
  logic               fire;
  logic               pin_req;
  logic               blank;
  logic [CAUSE_W-1:0] status;
  cfg_t               cfg_q, cfg_d;
  logic               cfg_en;
  logic               cfg_gpio;
  logic               stop_q, stop_d;

  rp_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rsync (
    .clk(clk), .arst_n(por_n), .rst_n_o(rst_sync_n)
  );

  assign cfg_gpio = cfg_q.gpio;
  assign blank    = active | cfg_gpio;

  rp_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_sync_n), .pad_in(pad_in), .blank(blank), .pin_req(pin_req)
  );

  rp_cause u_cause (
    .clk(clk), .rst_n(rst_sync_n), .busy(active), .lvd_req(lvd_req),
    .pin_req(pin_req), .int_req(int_req), .fire(fire), .status(status)
  );

  rp_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_str (
    .clk(clk), .rst_n(rst_sync_n), .load(fire), .active(active)
  );

  // Config register: reset role restored by every reset, frozen in stretch.
  assign cfg_en = fire | (cfg_we & ~active);

  always_comb begin
    if (fire) cfg_d = CFG_DEFAULT;
    else      cfg_d = cfg_t'(cfg_wdata);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cfg_q <= CFG_DEFAULT;
    else if (cfg_en)  cfg_q <= cfg_d;
  end

  // Stop entry only in reset role and outside a stretch.
  always_comb begin
    stop_d = stop_req & ~cfg_q.gpio & ~active;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) stop_q <= 1'b0;
    else             stop_q <= stop_d;
  end

  assign stop_grant = stop_q;
  assign sys_rst_n  = ~active;
  assign pad_oe     = active | (cfg_q.gpio & ~cfg_q.level);
  assign pad_pu_en  = active | ~cfg_q.gpio | cfg_q.pu;

  always_comb begin
    rd_data = '0;
    if (rd_sel) rd_data[CFG_W-1:0]   = cfg_q;
    else        rd_data[CAUSE_W-1:0] = status;
  end
endmodule

// File: rtl/rstpad_ctrl_chk.sv
module rstpad_ctrl_chk #(
  parameter int STRETCH_CYC = 66
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_rst_n,
  input logic       pad_oe,
  input logic       pad_pu_en,
  input logic       stop_req,
  input logic       stop_grant,
  input logic       cfg_gpio,
  input logic [3:0] status
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= '0;
    else if (!sys_rst_n) low_cnt <= low_cnt + 16'd1;
    else                 low_cnt <= '0;
  end

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status) == 1); // R3
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_n && $past(sys_rst_n)) |-> $stable(status)); // R4
  AST_STRETCH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> (low_cnt == 16'(STRETCH_CYC))); // R2
  AST_OE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |-> pad_oe); // R2
  AST_PU_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |-> pad_pu_en); // R10
  AST_STOP_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_grant |-> ($past(stop_req) && !$past(cfg_gpio) && $past(sys_rst_n))); // R11
endmodule

bind rstpad_ctrl rstpad_ctrl_chk #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sys_rst_n(sys_rst_n), .pad_oe(pad_oe),
  .pad_pu_en(pad_pu_en), .stop_req(stop_req), .stop_grant(stop_grant),
  .cfg_gpio(cfg_gpio), .status(status)
);

// File: tb/sim_rstpad_ctrl.sv
module sim_rstpad_ctrl;
  localparam int STRETCH = 66;

  logic       clk;
  logic       por_n, lvd_req, int_req, pad_in, pad_oe, pad_pu_en;
  logic       cfg_we, stop_req, stop_grant, rd_sel, sys_rst_n;
  logic [2:0] cfg_wdata;
  logic [7:0] rd_data;
  logic       ext_low;
  int         checks, errors;
  logic       done;
  logic [3:0] exp_stat;

  // Vector fields: {lvd, int, pin, expected status[3:0]}
  localparam logic [6:0] VEC [7] = '{
    7'b100_0010, 7'b010_1000, 7'b001_0100, 7'b110_0010,
    7'b011_0100, 7'b101_0010, 7'b111_0010
  };

  assign pad_in = ~(pad_oe | ext_low);

  rstpad_ctrl u0 (
    .clk(clk), .por_n(por_n), .lvd_req(lvd_req), .int_req(int_req), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_pu_en(pad_pu_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .stop_req(stop_req), .stop_grant(stop_grant), .rd_sel(rd_sel), .rd_data(rd_data),
    .sys_rst_n(sys_rst_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output int val);
    rd_sel = sel; #1; val = int'(rd_data);
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (pad_oe && n < 500) begin n++; tick(); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v, n;
    checks = 0; errors = 0; done = 1'b0;
    por_n = 1'b0; lvd_req = 1'b0; int_req = 1'b0; ext_low = 1'b0;
    cfg_we = 1'b0; cfg_wdata = '0; stop_req = 1'b0; rd_sel = 1'b0;
    repeat (4) tick();
    // R1: reset state
    check("R1 oe", pad_oe, 1); check("R1 rst", sys_rst_n, 0);
    check("R1 pu", pad_pu_en, 1);
    rd(0, v); check("R1 status", v, 1);
    rd(1, v); check("R1 cfg", v, 6);
    por_n = 1'b1;
    count_low(n); check("R1 stretch", n, STRETCH + 2);
    exp_stat = 4'b0001;

    // R11: stop grant in reset role
    stop_req = 1'b1; tick(); stop_req = 1'b0;
    check("R11 grant", stop_grant, 1);
    tick(); check("R11 drop", stop_grant, 0);

    // Table walk: R2 R3 R4 R5 R7
    foreach (VEC[i]) begin
      ext_low = VEC[i][4];
      repeat (3) tick();
      if (VEC[i][4]) check("R5 not early", pad_oe, 0);
      lvd_req = VEC[i][6]; int_req = VEC[i][5];
      tick();
      lvd_req = 1'b0; int_req = 1'b0; ext_low = 1'b0;
      check("R2 rst low", sys_rst_n, 0);
      rd(0, v); check("R3 cause", v, int'(VEC[i][3:0]));
      count_low(n); check("R2 length", n, STRETCH);
      repeat (5) tick();
      check("R7 no retrigger", pad_oe, 0);
      check("R7 rst high", sys_rst_n, 1);
      rd(0, v); check("R4 hold", v, int'(VEC[i][3:0]));
      exp_stat = VEC[i][3:0];
    end

    // R6: one-period glitch
    ext_low = 1'b1; tick(); ext_low = 1'b0;
    repeat (6) tick();
    check("R6 oe", pad_oe, 0);
    rd(0, v); check("R6 status", v, int'(exp_stat));

    // R8 R12: requests and writes during stretch
    int_req = 1'b1; tick(); int_req = 1'b0;
    n = 0;
    while (pad_oe && n < 500) begin
      if (n == 10) begin lvd_req = 1'b1; cfg_we = 1'b1; cfg_wdata = 3'b001; end
      else begin lvd_req = 1'b0; cfg_we = 1'b0; end
      n++; tick();
    end
    lvd_req = 1'b0; cfg_we = 1'b0;
    check("R8 length", n, STRETCH);
    rd(0, v); check("R8 cause", v, 8);
    rd(1, v); check("R12 cfg", v, 6);
    exp_stat = 4'b1000;

    // R9: GPIO mode
    cfg_we = 1'b1; cfg_wdata = 3'b101; tick(); cfg_we = 1'b0;
    check("R9 oe low level", pad_oe, 1);
    check("R9 pu", pad_pu_en, 1);
    check("R9 rst", sys_rst_n, 1);
    rd(1, v); check("R9 cfg", v, 5);
    cfg_we = 1'b1; cfg_wdata = 3'b011; tick(); cfg_we = 1'b0;
    check("R9 oe released", pad_oe, 0);
    check("R9 pu off", pad_pu_en, 0);
    ext_low = 1'b1; repeat (8) tick();
    check("R9 pin ignored", sys_rst_n, 1);
    ext_low = 1'b0; tick();
    rd(0, v); check("R9 status", v, int'(exp_stat));
    stop_req = 1'b1; tick(); stop_req = 1'b0;
    check("R11 refused gpio", stop_grant, 0);

    // R10: reset restores reset role
    lvd_req = 1'b1; tick(); lvd_req = 1'b0;
    check("R10 pu", pad_pu_en, 1);
    rd(1, v); check("R10 cfg", v, 6);
    stop_req = 1'b1; tick(); stop_req = 1'b0;
    check("R11 refused stretch", stop_grant, 0);
    count_low(n); check("R2 length gpio", n, STRETCH - 1);
    rd(0, v); check("R3 lvd", v, 2);

    finish_run();
  end
endmodule